// File: doc/BRIEF.md
# Timer Channel Trigger Selector

This block forms the restart trigger for a single timer/counter channel. Four sources can restart the channel counter:

- a software strobe;
- a block-wide synchronization strobe, which all channels receive in the same cycle;
- a match between the running count and the channel's C compare value;
- an edge on an external line.

The block merges the enabled sources into one registered pulse, one clock wide, that the counter uses to clear and restart. The configuration fields are static register values driven from outside. The counter, the clock selection, the waveform outputs and the register interface are not part of the block.

The external source depends on the channel mode. In capture mode a select bit picks channel line A or channel line B. In waveform mode a 2-bit select picks line B or one of three auxiliary inputs, and that path also needs a separate enable bit. Every external line passes through its own synchronizer and keeps its own history flop. Changing a select therefore never creates a false edge. A 2-bit edge field chooses the qualifying edge, and the code that means "off" disables the external path completely.

Top module: `tmr_trig_sel`

## Requirements
- R1: A high `sw_strobe` sampled at clock edge k drives `trig_out` high in the cycle after edge k.
- R2: A high `sync_strobe` behaves exactly like `sw_strobe`: sampled at edge k, it drives `trig_out` high in the cycle after edge k.
- R3: When `cnt_val` equals `cmp_c` at edge k and `cmp_trig_en` is 1, `trig_out` is high after edge k. When `cmp_trig_en` is 0, the match alone produces no trigger.
- R4: With `wave_mode`=0, `cap_src_sel`=0 selects line A and `cap_src_sel`=1 selects line B as the external source. The unselected line has no effect, and `ext_trig_en` is ignored in this mode.
- R5: With `wave_mode`=1, `wave_src_sel` selects the external source: 0 selects line B, and 1, 2 and 3 select `aux_in[0]`, `aux_in[1]` and `aux_in[2]`. Line A has no effect. An edge triggers only while `ext_trig_en`=1.
- R6: `edge_sel` is encoded as follows: 0 = off, so no external trigger; 1 = rising edges; 2 = falling edges; 3 = both edges. Edges of the other polarity are ignored.
- R7: Suppose a qualifying level change on the selected external line is first sampled at edge k. Then `trig_out` is high for exactly one cycle, after edge k+SYNC_STAGES, and no trigger pulse appears without a cause.
- R8: While `rst_n` is low, `trig_out` is 0 whatever the strobes do. When several sources fire in the same cycle, the result is a single one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_strobe | input | 1 | Software trigger strobe |
| sync_strobe | input | 1 | Block-wide synchronization strobe |
| cnt_val | input | CNT_W | Current channel count |
| cmp_c | input | CNT_W | C compare value |
| cmp_trig_en | input | 1 | Enables the trigger on a compare match |
| wave_mode | input | 1 | 0 = capture mode, 1 = waveform mode |
| cap_src_sel | input | 1 | Capture-mode external source: 0 = line A, 1 = line B |
| wave_src_sel | input | WSEL_W | Waveform-mode external source: 0 = line B, k = aux_in[k-1] |
| ext_trig_en | input | 1 | Waveform-mode external trigger enable |
| edge_sel | input | 2 | Qualifying edge: 0 off, 1 rising, 2 falling, 3 both |
| line_a | input | 1 | Asynchronous channel line A |
| line_b | input | 1 | Asynchronous channel line B |
| aux_in | input | NUM_AUX | Asynchronous auxiliary inputs |
| trig_out | output | 1 | One-cycle channel trigger pulse |

## Verification
The checker assumes that every level on an external line lasts longer than one clock period, so a synchronizer cannot swallow it. It also assumes the lines are low while reset is applied, because the history flops clear to zero. The quiet-path properties assume nothing about the line levels: with the external path gated off and no strobe or enabled match, the next output must be low. The stimulus changes each external line only at a falling clock edge and holds the new level for several cycles. It keeps all lines low during reset and changes the selects and the edge field only while the lines are steady.

// File: rtl/tmr_trig_pkg.sv
package tmr_trig_pkg;

   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_mode_t;

   // Qualify one line's transition against the chosen edge mode.
   function automatic logic edge_hit(edge_mode_t mode, logic cur, logic prev);
      case (mode)
         EDGE_RISE: return cur & ~prev;
         EDGE_FALL: return ~cur & prev;
         EDGE_ANY:  return cur ^ prev;
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/tmr_line_sync.sv
module tmr_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic cur,
   output logic prev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("tmr_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              hist;

   // Stage 0 captures the raw line; later stages shift it along.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= 1'b0;
      else        chain[0] <= line_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= 1'b0;
         else        chain[s] <= chain[s-1];
      end
   end

   // One more flop keeps the previous synchronized level.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= 1'b0;
      else        hist <= chain[STAGES-1];
   end

   assign cur  = chain[STAGES-1];
   assign prev = hist;

endmodule

// File: rtl/tmr_ext_pick.sv
module tmr_ext_pick
   import tmr_trig_pkg::*;
#(
   parameter int NUM_AUX = 3,
   localparam int NL     = NUM_AUX + 2,
   localparam int WSEL_W = $clog2(NUM_AUX + 1)
) (
   input  logic [NL-1:0]     cur_v,
   input  logic [NL-1:0]     prev_v,
   input  logic              wave_mode,
   input  logic              cap_src_sel,
   input  logic [WSEL_W-1:0] wave_src_sel,
   input  logic              ext_trig_en,
   input  logic [1:0]        edge_sel,
   output logic              ext_fire
);

   // Line order: 0 = line A, 1 = line B, 2.. = auxiliary inputs.
   logic sel_cur, sel_prev, armed;

   always_comb begin
      sel_cur  = 1'b0;
      sel_prev = 1'b0;
      if (wave_mode) begin
         for (int k = 0; k <= NUM_AUX; k++) begin
            if (wave_src_sel == WSEL_W'(k)) begin
               sel_cur  = cur_v[k+1];
               sel_prev = prev_v[k+1];
            end
         end
      end else begin
         sel_cur  = cap_src_sel ? cur_v[1]  : cur_v[0];
         sel_prev = cap_src_sel ? prev_v[1] : prev_v[0];
      end
   end

   assign armed    = wave_mode ? ext_trig_en : 1'b1;
   assign ext_fire = armed & edge_hit(edge_mode_t'(edge_sel), sel_cur, sel_prev);

endmodule

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
   import tmr_trig_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int NUM_AUX     = 3,
   parameter int SYNC_STAGES = 2,
   localparam int WSEL_W     = $clog2(NUM_AUX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_strobe,
   input  logic              sync_strobe,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic [CNT_W-1:0]  cmp_c,
   input  logic              cmp_trig_en,
   input  logic              wave_mode,
   input  logic              cap_src_sel,
   input  logic [WSEL_W-1:0] wave_src_sel,
   input  logic              ext_trig_en,
   input  logic [1:0]        edge_sel,
   input  logic              line_a,
   input  logic              line_b,
   input  logic [NUM_AUX-1:0] aux_in,
   output logic              trig_out
);

   localparam int NL = NUM_AUX + 2;

   if (CNT_W < 1) begin : g_bad_width
      $error("tmr_trig_sel: CNT_W must be positive");
   end
   if (NUM_AUX < 1) begin : g_bad_aux
      $error("tmr_trig_sel: NUM_AUX must be at least 1");
   end

   logic [NL-1:0] raw_v, cur_v, prev_v;
   logic          ext_fire, cmp_fire, any_fire, trig_q;

   assign raw_v = {aux_in, line_b, line_a};

   for (genvar i = 0; i < NL; i++) begin : g_line
      tmr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_in (raw_v[i]),
         .cur     (cur_v[i]),
         .prev    (prev_v[i])
      );
   end

   tmr_ext_pick #(.NUM_AUX(NUM_AUX)) u_pick (
      .cur_v        (cur_v),
      .prev_v       (prev_v),
      .wave_mode    (wave_mode),
      .cap_src_sel  (cap_src_sel),
      .wave_src_sel (wave_src_sel),
      .ext_trig_en  (ext_trig_en),
      .edge_sel     (edge_sel),
      .ext_fire     (ext_fire)
   );

   assign cmp_fire = cmp_trig_en & (cnt_val == cmp_c);
   assign any_fire = sw_strobe | sync_strobe | cmp_fire | ext_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_q <= 1'b0;
      else        trig_q <= any_fire;
   end

   assign trig_out = trig_q;

endmodule

// File: rtl/tmr_trig_chk.sv
module tmr_trig_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sw_strobe,
   input logic             sync_strobe,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] cmp_c,
   input logic             cmp_trig_en,
   input logic             wave_mode,
   input logic             ext_trig_en,
   input logic [1:0]       edge_sel,
   input logic             trig_out
);

   logic quiet;
   assign quiet = !sw_strobe && !sync_strobe && !(cmp_trig_en && (cnt_val == cmp_c));

   AST_SW_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      sw_strobe |=> trig_out);  // R1
   AST_SYNC_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      sync_strobe |=> trig_out);  // R2
   AST_CMP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_trig_en && cnt_val == cmp_c) |=> trig_out);  // R3
   AST_CMP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_trig_en && !sw_strobe && !sync_strobe && edge_sel == 2'd0) |=> !trig_out);  // R3
   AST_EDGE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && edge_sel == 2'd0) |=> !trig_out);  // R6
   AST_WAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet && wave_mode && !ext_trig_en) |=> !trig_out);  // R5

endmodule

bind tmr_trig_sel tmr_trig_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sw_strobe   (sw_strobe),
   .sync_strobe (sync_strobe),
   .cnt_val     (cnt_val),
   .cmp_c       (cmp_c),
   .cmp_trig_en (cmp_trig_en),
   .wave_mode   (wave_mode),
   .ext_trig_en (ext_trig_en),
   .edge_sel    (edge_sel),
   .trig_out    (trig_out)
);

// File: tb/sim_tmr_trig_sel.sv
`timescale 1ns/1ps
module sim_tmr_trig_sel;

   localparam int CNT_W       = 16;
   localparam int NUM_AUX     = 3;
   localparam int SYNC_STAGES = 2;
   localparam int WSEL_W      = $clog2(NUM_AUX + 1);
   localparam int EXT_LAT     = SYNC_STAGES + 1;  // negedge drive -> observed cycle

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sw_strobe = 1'b0, sync_strobe = 1'b0;
   logic [CNT_W-1:0] cnt_val = '0;
   logic [CNT_W-1:0] cmp_c = 16'h00FF;
   logic cmp_trig_en = 1'b0, wave_mode = 1'b0, cap_src_sel = 1'b0, ext_trig_en = 1'b0;
   logic [WSEL_W-1:0] wave_src_sel = '0;
   logic [1:0] edge_sel = 2'd0;
   logic line_a = 1'b0, line_b = 1'b0;
   logic [NUM_AUX-1:0] aux_in = '0;
   logic trig_out;

   tmr_trig_sel #(.CNT_W(CNT_W), .NUM_AUX(NUM_AUX), .SYNC_STAGES(SYNC_STAGES)) u0 (
      .clk(clk), .rst_n(rst_n), .sw_strobe(sw_strobe), .sync_strobe(sync_strobe),
      .cnt_val(cnt_val), .cmp_c(cmp_c), .cmp_trig_en(cmp_trig_en),
      .wave_mode(wave_mode), .cap_src_sel(cap_src_sel), .wave_src_sel(wave_src_sel),
      .ext_trig_en(ext_trig_en), .edge_sel(edge_sel), .line_a(line_a), .line_b(line_b),
      .aux_in(aux_in), .trig_out(trig_out)
   );

   always #4 clk = ~clk;  // 125 MHz

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    cyc;
      bit    exp;
      string req;
   } item_t;
   item_t sb[$];

   int total = 0;
   int bad   = 0;

   task automatic check(bit got, bit exp, string req, string what);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s: got=%0b exp=%0b (cycle %0d)", req, what, got, exp, cyc);
      end
   endtask

   task automatic expect_at(int c, bit e, string req);
      item_t it;
      it.cyc = c;
      it.exp = e;
      it.req = req;
      sb.push_back(it);
   endtask

   // Monitor: pops scheduled items and flags unscheduled pulses.
   always @(negedge clk) begin
      bit seen1;
      seen1 = 1'b0;
      if (rst_n) begin
         while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            item_t it;
            it = sb.pop_front();
            if (it.cyc < cyc) check(1'b0, 1'b1, it.req, "stale item");
            else begin
               check(trig_out, it.exp, it.req, "scheduled");
               if (it.exp) seen1 = 1'b1;
            end
         end
         if (trig_out && !seen1) check(trig_out, 1'b0, "R7", "unscheduled pulse");
      end
   end

   task automatic idle(int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic strobe(bit sw, bit sy, bit e, string req);
      int n;
      @(negedge clk);
      sw_strobe = sw; sync_strobe = sy; n = cyc;
      expect_at(n + 1, e, req);
      expect_at(n + 2, 1'b0, req);
      @(negedge clk);
      sw_strobe = 1'b0; sync_strobe = 1'b0;
      idle(3);
   endtask

   task automatic cmp_match(bit en, bit e, string req);
      int n;
      @(negedge clk);
      cnt_val = cmp_c; cmp_trig_en = en; n = cyc;
      expect_at(n + 1, e, req);
      expect_at(n + 2, 1'b0, req);
      @(negedge clk);
      cnt_val = '0;
      idle(3);
      cmp_trig_en = 1'b0;
   endtask

   // idx: 0 = line A, 1 = line B, 2.. = aux_in[idx-2]
   task automatic line_step(int idx, bit v, bit e, string req);
      int n;
      @(negedge clk);
      if (idx == 0) line_a = v;
      else if (idx == 1) line_b = v;
      else aux_in[idx-2] = v;
      n = cyc;
      expect_at(n + EXT_LAT, e, req);
      expect_at(n + EXT_LAT + 1, 1'b0, req);
      idle(EXT_LAT + 3);
   endtask

   task automatic cfg(bit wm, bit cs, int ws, bit en, logic [1:0] es);
      @(negedge clk);
      wave_mode = wm; cap_src_sel = cs; wave_src_sel = WSEL_W'(ws);
      ext_trig_en = en; edge_sel = es;
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(200000 * 8);
      total++; bad++;
      $display("FAIL R7 watchdog: got=hung exp=finished");
      summary();
      $finish;
   end

   initial begin
      // R8: reset holds the output low even with strobes active
      idle(2);
      check(trig_out, 1'b0, "R8", "reset idle");
      sw_strobe = 1'b1; sync_strobe = 1'b1;
      idle(2);
      check(trig_out, 1'b0, "R8", "strobes during reset");
      sw_strobe = 1'b0; sync_strobe = 1'b0;
      rst_n = 1'b1;
      idle(3);

      strobe(1'b1, 1'b0, 1'b1, "R1");
      strobe(1'b0, 1'b1, 1'b1, "R2");
      strobe(1'b1, 1'b1, 1'b1, "R8");   // merged sources: single pulse
      cmp_match(1'b1, 1'b1, "R3");
      cmp_match(1'b0, 1'b0, "R3");

      // Capture mode, rising edges, line A
      cfg(1'b0, 1'b0, 0, 1'b0, 2'd1);
      line_step(0, 1'b1, 1'b1, "R4");
      line_step(1, 1'b1, 1'b0, "R4");   // unselected line B ignored
      line_step(0, 1'b0, 1'b0, "R6");   // falling ignored in rising mode
      // Capture mode, falling edges, line B
      cfg(1'b0, 1'b1, 0, 1'b0, 2'd2);
      line_step(1, 1'b0, 1'b1, "R6");
      line_step(1, 1'b1, 1'b0, "R6");
      // Both edges
      cfg(1'b0, 1'b1, 0, 1'b0, 2'd3);
      line_step(1, 1'b0, 1'b1, "R6");
      line_step(1, 1'b1, 1'b1, "R7");
      // Off
      cfg(1'b0, 1'b1, 0, 1'b0, 2'd0);
      line_step(1, 1'b0, 1'b0, "R6");

      // Waveform mode, rising, line B
      cfg(1'b1, 1'b0, 0, 1'b1, 2'd1);
      line_step(1, 1'b1, 1'b1, "R5");
      line_step(0, 1'b1, 1'b0, "R5");   // line A ignored in waveform mode
      cfg(1'b1, 1'b0, 1, 1'b1, 2'd1);
      line_step(2, 1'b1, 1'b1, "R5");
      cfg(1'b1, 1'b0, 2, 1'b1, 2'd1);
      line_step(3, 1'b1, 1'b1, "R5");
      cfg(1'b1, 1'b0, 3, 1'b1, 2'd1);
      line_step(4, 1'b1, 1'b1, "R5");
      // Enable off gates the external path
      cfg(1'b1, 1'b0, 3, 1'b0, 2'd3);
      line_step(4, 1'b0, 1'b0, "R5");
      line_step(4, 1'b1, 1'b0, "R5");
      // Capture mode ignores the waveform enable
      cfg(1'b0, 1'b0, 0, 1'b0, 2'd3);
      line_step(0, 1'b0, 1'b1, "R4");

      idle(6);
      if (sb.size() != 0) check(1'b0, 1'b1, "R7", "items left over");
      summary();
      $finish;
   end

endmodule